// File: doc/BRIEF.md
# CAN Receive Frame Router

This block decides where a received CAN frame goes once its fields are decoded. It takes the frame's identifier, IDE and RTR bits and compares them at once against a bank of receive mailbox filters and a set of receive FIFO filters. It then reports one of four outcomes: no match, a mailbox index to store into, a FIFO filter index, or a mailbox that must send an automatic answer to a remote request.

The filter table comes in on flat register-style ports. Each mailbox has an identifier, IDE and RTR bits, a 4-bit state code and its own mask. Each FIFO filter has an identifier, IDE and RTR bits and its own mask, or all FIFO filters share one global mask. Three control bits are held inside the block: the search order, the remote-request storing mode and full IDE/RTR comparison for mailboxes. They can be loaded only while the freeze input is high. One frame-valid strobe gives exactly one result strobe two clock edges later.

Top module: `can_rx_router`

## Requirements
- R1: While reset is active and after it is released, res_vld, rsp_req and cfg_q are all zero.
- R2: cfg_q loads cfg_wdata (bit 2 = mailboxes searched first, bit 1 = store remote requests, bit 0 = full IDE/RTR compare for mailboxes) on an edge where both cfg_we and freeze are high. A write while freeze is low is ignored and cfg_q keeps its value.
- R3: A frame sampled with frm_vld high on edge k gives res_vld high for exactly one cycle after edge k+1. res_vld never rises without such a frame.
- R4: Mask bit 1 means the bit must match and 0 means don't care (mask bits [28:0] identifier, [29] RTR, [30] IDE). A frame with IDE=0 compares only identifier bits [10:0]. A frame with IDE=1 compares all 29 bits.
- R5: Only mailboxes with code 4'b0100 (empty) or 4'b0010 (full) receive frames. Only mailboxes with index up to min(NUM_MB-1, maxmb) take part in any search.
- R6: Among matching mailboxes, and among matching FIFO filters, the lowest index wins.
- R7: With cfg bit 2 clear, a FIFO hit takes precedence over a mailbox hit. With it set, a mailbox hit takes precedence over a FIFO hit. The other kind is used only when the first kind has no hit.
- R8: With cfg bit 0 clear, a mailbox always compares IDE and never compares RTR, regardless of mask bits 30 and 29. With it set, IDE and RTR are compared under those mask bits.
- R9: FIFO filters always compare IDE and RTR under their mask bits 30 and 29, whatever cfg bit 0 holds.
- R10: With fifo_indiv_en low, every FIFO filter uses fifo_gmask. With it high, each filter uses its own mask.
- R11: A remote frame (RTR=1) with cfg bit 1 clear first looks for the lowest in-range mailbox with code 4'b1010 whose IDE equals the frame's and whose identifier equals the frame's exactly over the compared width. If one is found, the result is hit code 3 with that index and rsp_req pulses with res_vld. If none is found, normal matching applies.
- R12: With cfg bit 1 set, a remote frame is matched like a data frame, and rsp_req stays low.
- R13: Hit codes are 0 = none, 1 = mailbox store, 2 = FIFO filter, 3 = mailbox answer. res_idx is 0 when there is no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze | input | 1 | Controller is in freeze mode; enables control writes |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 3 | Control write data {mb_first, store_remote, full_cmp} |
| cfg_q | output | 3 | Current control bits |
| maxmb | input | MAXMB_W | Programmable highest mailbox index |
| fifo_indiv_en | input | 1 | FIFO filters use their own masks |
| fifo_gmask | input | 31 | Shared FIFO mask {IDE, RTR, ID} |
| mb_code | input | NUM_MB*4 | Mailbox state codes |
| mb_id | input | NUM_MB*29 | Mailbox identifiers |
| mb_ide | input | NUM_MB | Mailbox IDE bits |
| mb_rtr | input | NUM_MB | Mailbox RTR bits |
| mb_mask | input | NUM_MB*31 | Mailbox masks {IDE, RTR, ID} |
| ff_id | input | NUM_FF*29 | FIFO filter identifiers |
| ff_ide | input | NUM_FF | FIFO filter IDE bits |
| ff_rtr | input | NUM_FF | FIFO filter RTR bits |
| ff_mask | input | NUM_FF*31 | FIFO filter masks {IDE, RTR, ID} |
| frm_vld | input | 1 | Decoded frame valid strobe |
| frm_id | input | 29 | Frame identifier (standard frames in [10:0]) |
| frm_ide | input | 1 | Frame IDE bit |
| frm_rtr | input | 1 | Frame RTR bit |
| res_vld | output | 1 | Result strobe |
| res_hit | output | 2 | Hit code |
| res_idx | output | IXW | Winning mailbox or FIFO filter index |
| rsp_req | output | 1 | Automatic remote answer request |

## Verification
The hardest state to reach from the ports is a remote frame that an answer mailbox, a receive mailbox and a FIFO filter could all claim at the same time. The outcome must then be decided by the storing bit, the search order and the maximum-mailbox limit together. Directed sequences build exactly that table and step the control bits through freeze-mode writes, including a maxmb value that hides the answer mailbox. A long random phase draws identifiers from a small pool so that overlapping hits are common. Every result is compared against a behavioural model on each clock.

// File: rtl/can_rx_router.sv
module can_rx_router #(
  parameter int NUM_MB  = 16,
  parameter int NUM_FF  = 8,
  parameter int MAXMB_W = 7,
  parameter int MBI     = $clog2(NUM_MB),
  parameter int FFI     = $clog2(NUM_FF),
  parameter int IXW     = (MBI > FFI) ? MBI : FFI
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  freeze,
  input  logic                  cfg_we,
  input  logic [2:0]            cfg_wdata,
  output logic [2:0]            cfg_q,
  input  logic [MAXMB_W-1:0]    maxmb,
  input  logic                  fifo_indiv_en,
  input  logic [30:0]           fifo_gmask,
  input  logic [NUM_MB*4-1:0]   mb_code,
  input  logic [NUM_MB*29-1:0]  mb_id,
  input  logic [NUM_MB-1:0]     mb_ide,
  input  logic [NUM_MB-1:0]     mb_rtr,
  input  logic [NUM_MB*31-1:0]  mb_mask,
  input  logic [NUM_FF*29-1:0]  ff_id,
  input  logic [NUM_FF-1:0]     ff_ide,
  input  logic [NUM_FF-1:0]     ff_rtr,
  input  logic [NUM_FF*31-1:0]  ff_mask,
  input  logic                  frm_vld,
  input  logic [28:0]           frm_id,
  input  logic                  frm_ide,
  input  logic                  frm_rtr,
  output logic                  res_vld,
  output logic [1:0]            res_hit,
  output logic [IXW-1:0]        res_idx,
  output logic                  rsp_req
);

  localparam logic [3:0] CODE_EMPTY  = 4'b0100;
  localparam logic [3:0] CODE_FULL   = 4'b0010;
  localparam logic [3:0] CODE_ANSWER = 4'b1010;

  typedef enum logic [1:0] {HIT_NONE = 2'd0, HIT_MB = 2'd1, HIT_FF = 2'd2, HIT_ANS = 2'd3} hit_e;

  logic mb_first, store_rem, full_cmp;
  assign mb_first  = cfg_q[2];
  assign store_rem = cfg_q[1];
  assign full_cmp  = cfg_q[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg_q <= '0;
    else if (freeze && cfg_we) cfg_q <= cfg_wdata;

  logic        pend;
  logic [28:0] f_id;
  logic        f_ide, f_rtr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend  <= 1'b0;
      f_id  <= '0;
      f_ide <= 1'b0;
      f_rtr <= 1'b0;
    end else begin
      pend <= frm_vld;
      if (frm_vld) begin
        f_id  <= frm_id;
        f_ide <= frm_ide;
        f_rtr <= frm_rtr;
      end
    end

  logic [MBI-1:0] last_mb;
  always_comb
    if (int'(maxmb) >= NUM_MB - 1) last_mb = MBI'(NUM_MB - 1);
    else                           last_mb = MBI'(maxmb);

  logic [28:0] width_m;
  assign width_m = f_ide ? {29{1'b1}} : 29'h7FF;

  logic [NUM_MB-1:0] mb_hit, ans_hit;
  logic [NUM_FF-1:0] ff_hit;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    logic [28:0] fid;
    logic [30:0] m;
    logic [3:0]  code;
    logic        in_rng, rx_ok, id_ok, ide_ok, rtr_ok;
    assign fid    = mb_id[i*29 +: 29];
    assign m      = mb_mask[i*31 +: 31];
    assign code   = mb_code[i*4 +: 4];
    assign in_rng = MBI'(i) <= last_mb;
    assign rx_ok  = (code == CODE_EMPTY) || (code == CODE_FULL);
    assign id_ok  = ((f_id ^ fid) & m[28:0] & width_m) == '0;
    assign ide_ok = (f_ide == mb_ide[i]) || (full_cmp && !m[30]);
    assign rtr_ok = !full_cmp || !m[29] || (f_rtr == mb_rtr[i]);
    assign mb_hit[i]  = in_rng && rx_ok && id_ok && ide_ok && rtr_ok;
    assign ans_hit[i] = in_rng && (code == CODE_ANSWER) && (f_ide == mb_ide[i]) &&
                        (((f_id ^ fid) & width_m) == '0);
  end

  for (genvar j = 0; j < NUM_FF; j++) begin : g_ff
    logic [28:0] fid;
    logic [30:0] m;
    assign fid = ff_id[j*29 +: 29];
    assign m   = fifo_indiv_en ? ff_mask[j*31 +: 31] : fifo_gmask;
    assign ff_hit[j] = (((f_id ^ fid) & m[28:0] & width_m) == '0) &&
                       (!m[30] || (f_ide == ff_ide[j])) &&
                       (!m[29] || (f_rtr == ff_rtr[j]));
  end

  logic [MBI-1:0] mb_sel, ans_sel;
  logic [FFI-1:0] ff_sel;

  always_comb begin
    mb_sel  = '0;
    ans_sel = '0;
    for (int k = NUM_MB - 1; k >= 0; k--) begin
      if (mb_hit[k])  mb_sel  = MBI'(k);
      if (ans_hit[k]) ans_sel = MBI'(k);
    end
  end

  always_comb begin
    ff_sel = '0;
    for (int k = NUM_FF - 1; k >= 0; k--)
      if (ff_hit[k]) ff_sel = FFI'(k);
  end

  logic mb_any, ff_any, answer;
  assign mb_any = |mb_hit;
  assign ff_any = |ff_hit;
  assign answer = f_rtr && !store_rem && (|ans_hit);

  hit_e           nxt_hit;
  logic [IXW-1:0] nxt_idx;

  always_comb begin
    nxt_hit = HIT_NONE;
    nxt_idx = '0;
    if (answer) begin
      nxt_hit = HIT_ANS;
      nxt_idx = IXW'(ans_sel);
    end else if (mb_first && mb_any) begin
      nxt_hit = HIT_MB;
      nxt_idx = IXW'(mb_sel);
    end else if (ff_any) begin
      nxt_hit = HIT_FF;
      nxt_idx = IXW'(ff_sel);
    end else if (mb_any) begin
      nxt_hit = HIT_MB;
      nxt_idx = IXW'(mb_sel);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      res_vld <= 1'b0;
      res_hit <= HIT_NONE;
      res_idx <= '0;
      rsp_req <= 1'b0;
    end else begin
      res_vld <= pend;
      rsp_req <= pend && answer;
      if (pend) begin
        res_hit <= nxt_hit;
        res_idx <= nxt_idx;
      end
    end

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(freeze && cfg_we) |=> $stable(cfg_q));

  p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && cfg_we) |=> (cfg_q == $past(cfg_wdata)));

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld |=> ##1 res_vld);

  p_strobe_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(frm_vld, 2));

  p_mb_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_hit[0]) |-> (int'(res_idx) <= int'($past(last_mb))));

  p_rsp_answer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_req |-> (res_vld && res_hit == HIT_ANS));

  p_store_rem_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_req |-> !$past(store_rem));

endmodule

// File: tb/sim_can_rx_router.sv
module sim_can_rx_router;
  localparam int CLK_PERIOD = 10;
  localparam int NMB = 16;
  localparam int NFF = 8;
  localparam int IXW = 4;
  localparam logic [30:0] FULLM = 31'h7FFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              freeze = 0, cfg_we = 0;
  logic [2:0]        cfg_wdata = '0, cfg_q;
  logic [6:0]        maxmb = 7'd127;
  logic              fifo_indiv_en = 1'b1;
  logic [30:0]       fifo_gmask = FULLM;
  logic [NMB*4-1:0]  mb_code_f;
  logic [NMB*29-1:0] mb_id_f;
  logic [NMB-1:0]    mb_ide_f, mb_rtr_f;
  logic [NMB*31-1:0] mb_mask_f;
  logic [NFF*29-1:0] ff_id_f;
  logic [NFF-1:0]    ff_ide_f, ff_rtr_f;
  logic [NFF*31-1:0] ff_mask_f;
  logic              frm_vld = 0, frm_ide = 0, frm_rtr = 0;
  logic [28:0]       frm_id = '0;
  logic              res_vld, rsp_req;
  logic [1:0]        res_hit;
  logic [IXW-1:0]    res_idx;

  logic [3:0]  t_code [NMB];
  logic [28:0] t_mid  [NMB];
  logic        t_mide [NMB], t_mrtr [NMB];
  logic [30:0] t_mm   [NMB];
  logic [28:0] t_fid  [NFF];
  logic        t_fide [NFF], t_frtr [NFF];
  logic [30:0] t_fm   [NFF];

  always_comb begin
    for (int i = 0; i < NMB; i++) begin
      mb_code_f[i*4 +: 4]  = t_code[i];
      mb_id_f[i*29 +: 29]  = t_mid[i];
      mb_ide_f[i]          = t_mide[i];
      mb_rtr_f[i]          = t_mrtr[i];
      mb_mask_f[i*31 +: 31] = t_mm[i];
    end
    for (int j = 0; j < NFF; j++) begin
      ff_id_f[j*29 +: 29]  = t_fid[j];
      ff_ide_f[j]          = t_fide[j];
      ff_rtr_f[j]          = t_frtr[j];
      ff_mask_f[j*31 +: 31] = t_fm[j];
    end
  end

  can_rx_router #(.NUM_MB(NMB), .NUM_FF(NFF), .MAXMB_W(7)) u0 (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .maxmb(maxmb), .fifo_indiv_en(fifo_indiv_en), .fifo_gmask(fifo_gmask),
    .mb_code(mb_code_f), .mb_id(mb_id_f), .mb_ide(mb_ide_f), .mb_rtr(mb_rtr_f),
    .mb_mask(mb_mask_f), .ff_id(ff_id_f), .ff_ide(ff_ide_f), .ff_rtr(ff_rtr_f),
    .ff_mask(ff_mask_f), .frm_vld(frm_vld), .frm_id(frm_id), .frm_ide(frm_ide),
    .frm_rtr(frm_rtr), .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx),
    .rsp_req(rsp_req));

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;
  logic [2:0] m_cfg = '0;
  int    q_due[$], q_hit[$], q_idx[$], q_rsp[$];
  string q_tag[$];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit id_eq(input logic [28:0] a, input logic [28:0] b, input logic [28:0] m, input bit ide);
    int bits = ide ? 29 : 11;
    for (int b2 = 0; b2 < bits; b2++)
      if (m[b2] && a[b2] !== b[b2]) return 0;
    return 1;
  endfunction

  function automatic void model(input logic [28:0] id, input bit ide, input bit rtr,
                                output int hit, output int idx, output int rsp);
    int last = (int'(maxmb) < NMB - 1) ? int'(maxmb) : NMB - 1;
    int mb = -1, ff = -1;
    hit = 0; idx = 0; rsp = 0;
    if (rtr && !m_cfg[1])
      for (int i = 0; i <= last; i++)
        if (t_code[i] == 4'b1010 && t_mide[i] == ide && id_eq(id, t_mid[i], FULLM[28:0], ide)) begin
          hit = 3; idx = i; rsp = 1;
          return;
        end
    for (int i = last; i >= 0; i--) begin
      bit ok = (t_code[i] == 4'b0100 || t_code[i] == 4'b0010) && id_eq(id, t_mid[i], t_mm[i][28:0], ide);
      if (m_cfg[0]) ok = ok && (!t_mm[i][30] || t_mide[i] == ide) && (!t_mm[i][29] || t_mrtr[i] == rtr);
      else          ok = ok && (t_mide[i] == ide);
      if (ok) mb = i;
    end
    for (int j = NFF - 1; j >= 0; j--) begin
      logic [30:0] m = fifo_indiv_en ? t_fm[j] : fifo_gmask;
      if (id_eq(id, t_fid[j], m[28:0], ide) && (!m[30] || t_fide[j] == ide) && (!m[29] || t_frtr[j] == rtr))
        ff = j;
    end
    if (m_cfg[2] && mb >= 0) begin hit = 1; idx = mb; end
    else if (ff >= 0)        begin hit = 2; idx = ff; end
    else if (mb >= 0)        begin hit = 1; idx = mb; end
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        chk(res_vld === 1'b1, q_tag[0], "res_vld", int'(res_vld), 1);
        chk(res_hit === 2'(q_hit[0]), q_tag[0], "res_hit", int'(res_hit), q_hit[0]);
        chk(res_idx === IXW'(q_idx[0]), q_tag[0], "res_idx", int'(res_idx), q_idx[0]);
        chk(rsp_req === 1'(q_rsp[0]), q_tag[0], "rsp_req", int'(rsp_req), q_rsp[0]);
        void'(q_due.pop_front()); void'(q_hit.pop_front()); void'(q_idx.pop_front());
        void'(q_rsp.pop_front()); void'(q_tag.pop_front());
      end else begin
        chk(res_vld === 1'b0 && rsp_req === 1'b0, "R3", "idle strobe", int'({res_vld, rsp_req}), 0);
      end
    end
  end

  task automatic send(input logic [28:0] id, input bit ide, input bit rtr, input string tag);
    int h, ix, r;
    @(posedge clk); #1;
    frm_id = id; frm_ide = ide; frm_rtr = rtr; frm_vld = 1'b1;
    model(id, ide, rtr, h, ix, r);
    q_due.push_back(cyc + 3); q_hit.push_back(h); q_idx.push_back(ix);
    q_rsp.push_back(r); q_tag.push_back(tag);
    @(posedge clk); #1 frm_vld = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input bit frz, input logic [2:0] d);
    @(posedge clk); #1;
    freeze = frz; cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0; freeze = 1'b0;
    if (frz) m_cfg = d;
    @(negedge clk);
    chk(cfg_q === m_cfg, "R2", "cfg_q", int'(cfg_q), int'(m_cfg));
    #1;
  endtask

  task automatic clear_table();
    for (int i = 0; i < NMB; i++) begin
      t_code[i] = 4'b0000; t_mid[i] = 29'h1FFF_FFFF; t_mide[i] = 1; t_mrtr[i] = 0; t_mm[i] = FULLM;
    end
    for (int j = 0; j < NFF; j++) begin
      t_fid[j] = 29'h1FFF_FFFF; t_fide[j] = 1; t_frtr[j] = 0; t_fm[j] = FULLM;
    end
  endtask

  task automatic set_mb(input int i, input logic [3:0] c, input logic [28:0] id, input bit ide, input bit rtr);
    t_code[i] = c; t_mid[i] = id; t_mide[i] = ide; t_mrtr[i] = rtr; t_mm[i] = FULLM;
  endtask

  task automatic set_ff(input int j, input logic [28:0] id, input bit ide, input bit rtr);
    t_fid[j] = id; t_fide[j] = ide; t_frtr[j] = rtr; t_fm[j] = FULLM;
  endtask

  function automatic logic [28:0] rnd_id();
    return 29'(($urandom_range(0, 3) << 18) | ($urandom_range(0, 1) << 12) | $urandom_range(0, 7));
  endfunction

  function automatic logic [3:0] rnd_code();
    case ($urandom_range(0, 4))
      0: return 4'b0000;
      1: return 4'b0010;
      2: return 4'b1010;
      3: return 4'b1000;
      default: return 4'b0100;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    clear_table();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(res_vld === 1'b0 && rsp_req === 1'b0, "R1", "outputs in reset", int'({res_vld, rsp_req}), 0);
    chk(cfg_q === 3'b000, "R1", "cfg_q in reset", int'(cfg_q), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(res_vld === 1'b0 && cfg_q === 3'b000, "R1", "after reset", int'({res_vld, cfg_q}), 0);

    cfg_write(0, 3'b111);
    cfg_write(1, 3'b100);
    cfg_write(0, 3'b011);

    set_mb(3, 4'b0100, 29'h123, 0, 0);
    set_mb(5, 4'b0010, 29'h123, 0, 0);
    send(29'h123, 0, 0, "R6");
    set_ff(2, 29'h123, 0, 0);
    set_ff(4, 29'h123, 0, 0);
    send(29'h123, 0, 0, "R7");
    cfg_write(1, 3'b000);
    send(29'h123, 0, 0, "R7");
    cfg_write(1, 3'b100);
    t_code[3] = 4'b0000;
    send(29'h123, 0, 0, "R5");
    maxmb = 7'd4;
    send(29'h123, 0, 0, "R5");
    set_ff(2, 29'h7FF, 1, 0);
    set_ff(4, 29'h7FF, 1, 0);
    send(29'h123, 0, 0, "R13");
    maxmb = 7'd127;

    t_code[3] = 4'b0100;
    send(29'h123 | 29'h100000, 0, 0, "R4");
    set_mb(7, 4'b0100, 29'h123 | 29'h100000, 1, 0);
    send(29'h123, 1, 0, "R4");
    send(29'h123 | 29'h100000, 1, 0, "R4");
    t_mm[7][20] = 1'b0;
    send(29'h123, 1, 0, "R4");

    cfg_write(1, 3'b110);
    send(29'h123, 0, 1, "R8");
    cfg_write(1, 3'b111);
    send(29'h123, 0, 1, "R8");
    t_mm[5][29] = 1'b0;
    send(29'h123, 0, 1, "R8");
    t_mm[5][30] = 1'b0;
    send(29'h123, 1, 1, "R8");

    clear_table();
    cfg_write(1, 3'b100);
    set_ff(1, 29'h200, 0, 0);
    send(29'h200, 0, 1, "R9");
    cfg_write(1, 3'b101);
    send(29'h200, 0, 1, "R9");
    t_fm[1][29] = 1'b0;
    send(29'h200, 0, 1, "R9");

    set_ff(1, 29'h201, 0, 0);
    t_fm[1] = 31'h7FFF_FFFE;
    send(29'h200, 0, 0, "R10");
    fifo_indiv_en = 1'b0;
    send(29'h200, 0, 0, "R10");
    fifo_gmask = 31'h7FFF_FFFE;
    send(29'h200, 0, 0, "R10");
    fifo_indiv_en = 1'b1;
    fifo_gmask = FULLM;

    clear_table();
    cfg_write(1, 3'b100);
    set_mb(6, 4'b1010, 29'h055, 0, 0);
    set_mb(2, 4'b0100, 29'h055, 0, 0);
    set_ff(0, 29'h055, 0, 1);
    send(29'h055, 0, 1, "R11");
    send(29'h055, 0, 0, "R11");
    cfg_write(1, 3'b110);
    send(29'h055, 0, 1, "R12");
    cfg_write(1, 3'b000);
    send(29'h055, 0, 1, "R11");
    t_mid[6] = 29'h054;
    t_mm[6] = 31'h7FFF_FFFE;
    send(29'h055, 0, 1, "R11");
    t_mid[6] = 29'h055;
    maxmb = 7'd5;
    send(29'h055, 0, 1, "R5");
    maxmb = 7'd127;

    for (int n = 0; n < 400; n++) begin
      if (n % 25 == 0) begin
        for (int i = 0; i < NMB; i++) begin
          t_code[i] = rnd_code(); t_mid[i] = rnd_id(); t_mide[i] = 1'($urandom_range(0, 1));
          t_mrtr[i] = 1'($urandom_range(0, 1));
          t_mm[i] = FULLM & ~31'($urandom_range(0, 7)) & ~(31'($urandom_range(0, 3)) << 29);
        end
        for (int j = 0; j < NFF; j++) begin
          t_fid[j] = rnd_id(); t_fide[j] = 1'($urandom_range(0, 1)); t_frtr[j] = 1'($urandom_range(0, 1));
          t_fm[j] = FULLM & ~31'($urandom_range(0, 7)) & ~(31'($urandom_range(0, 3)) << 29);
        end
        fifo_indiv_en = 1'($urandom_range(0, 1));
        fifo_gmask = FULLM & ~31'($urandom_range(0, 3));
        maxmb = 7'($urandom_range(0, 20));
        cfg_write(1, 3'($urandom_range(0, 7)));
      end
      send(rnd_id(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R4 R6 R7 R11 random");
    end

    repeat (4) @(posedge clk);
    chk(q_due.size() == 0, "R3", "pending results", q_due.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule